// File: doc/BRIEF.md
# Parallel I/O Port Block with Buzzer Output

This block gives a small 8-bit controller three parallel ports: port A and port B of eight lines each, and port C of five lines. Each port owns an output latch and a direction register, both reached over a simple register bus. The bus has an address, a write strobe, an operation code, a bit selector and write data. Read data is combinational from the address.

Writes can be plain byte writes or read-modify-write operations. A set, clear or complement operation reads the whole port as it currently appears, applies the change, and writes the result back to the addressed register. Each port carries a pull-high option that applies to the whole port. An input line that nothing outside drives reads 1 when that option is on and 0 when it is off.

The two lowest lines of port B can carry a complementary buzzer pair. The pair is derived from a timer toggle input and gated by the latch bit of the lowest line. Port A watches its input lines and emits a one-cycle wake pulse when any of them changes.

Top module: `gpio_buzz_port`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every direction register holds all ones, so all drive enables are 0. Every output latch holds all ones.
- R2: The output latches are at addresses 0x12 (A), 0x14 (B) and 0x16 (C). The direction registers are at 0x13, 0x15 and 0x17. A direction bit of 1 means input and 0 means output. Reading a direction address returns the register.
- R3: A line in output mode has its drive enable at 1 and drives its latch bit (CMOS push-pull, no open-drain). A line in input mode has its drive enable at 0.
- R4: Reading a latch address returns a port view. Input-mode bits show the resolved pad level; output-mode bits show the latch.
- R5: An input line is resolved as follows. When its external-drive flag is 1, it takes the pad input value. Otherwise it reads 1 if the port's pull-high bit is on (pull_en bit 0 = A, 1 = B, 2 = C), and 0 if that bit is off.
- R6: A write with bus_op 0 stores bus_wdata. Op 1 sets bit bus_bsel, op 2 clears bit bus_bsel, and op 3 inverts all bits. Ops 1 to 3 start from the value a read of that address returns and store the result.
- R7: Port C has five lines. Bits 7..5 of both port C addresses read 0, and writes to those bits have no effect.
- R8: With buz_en set, pad output B0 carries tmr_tog AND latch bit B0, and pad output B1 carries NOT tmr_tog AND latch bit B0. This gives a steady 0 on both when latch bit B0 is 0.
- R9: With buz_en set, latch bit B1 has no effect on either buzzer line.
- R10: Lines B0 and B1 in input mode keep drive enable 0 and read back the resolved pad level, whatever buz_en is.
- R11: The wake output is registered. It goes high for one cycle after a clock edge at which some port A input-mode line has a resolved level different from its level at the previous edge. Output-mode lines never wake, and the first edge after reset never wakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_op | input | 2 | 0 write, 1 set bit, 2 clear bit, 3 complement |
| bus_bsel | input | 3 | Bit index for set and clear |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pull_en | input | 3 | Pull-high option per port (bit 0 A, 1 B, 2 C) |
| buz_en | input | 1 | Buzzer option on port B lines 0 and 1 |
| tmr_tog | input | 1 | Timer overflow toggle |
| pa_in | input | PA_W | Port A pad levels |
| pa_ext | input | PA_W | Port A external-drive flags |
| pb_in | input | PB_W | Port B pad levels |
| pb_ext | input | PB_W | Port B external-drive flags |
| pc_in | input | PC_W | Port C pad levels |
| pc_ext | input | PC_W | Port C external-drive flags |
| pa_oe | output | PA_W | Port A drive enables |
| pa_out | output | PA_W | Port A pad output values |
| pb_oe | output | PB_W | Port B drive enables |
| pb_out | output | PB_W | Port B pad output values |
| pc_oe | output | PC_W | Port C drive enables |
| pc_out | output | PC_W | Port C pad output values |
| wake | output | 1 | One-cycle wake pulse from port A |

## Verification
The bench builds the block with its defaults: PA_W = 8, PB_W = 8 and PC_W = 5. With these values the short port C is exercised, so the masking of its three missing bits on read, write and complement can be observed at the bus. Full-width ports A and B let every bit-select value from 0 to 7 reach a real line. The buzzer pair on B0/B1 is present for every combination of direction, latch, toggle and option.

// File: rtl/gpio_buzz_pkg.sv
// Package: shared register addresses, bus operation codes and the
// read-modify-write helper used by every port bank.
package gpio_buzz_pkg;

    localparam logic [7:0] ADDR_A_DAT = 8'h12;
    localparam logic [7:0] ADDR_A_CTL = 8'h13;
    localparam logic [7:0] ADDR_B_DAT = 8'h14;
    localparam logic [7:0] ADDR_B_CTL = 8'h15;
    localparam logic [7:0] ADDR_C_DAT = 8'h16;
    localparam logic [7:0] ADDR_C_CTL = 8'h17;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_CPL   = 2'd3
    } bus_op_e;

    // Compute the value stored by a bus operation from the current read value.
    function automatic logic [7:0] apply_op(bus_op_e op, logic [2:0] bsel,
                                            logic [7:0] cur, logic [7:0] wd);
        logic [7:0] r;
        case (op)
            OP_WRITE: r = wd;
            OP_SET:   r = cur | (8'b1 << bsel);
            OP_CLR:   r = cur & ~(8'b1 << bsel);
            default:  r = ~cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_port_bank.sv
// Module: one port's output latch and direction register plus read logic.
// Assumes W <= 8; bits above W read 0 and ignore writes. Input lines are
// resolved from pad level, external-drive flag and the port's pull-high.
module gpio_port_bank
    import gpio_buzz_pkg::*;
#(
    parameter int         W         = 8,
    parameter logic [7:0] DATA_ADDR = 8'h12,
    parameter logic [7:0] CTRL_ADDR = 8'h13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [7:0]   bus_addr,
    input  logic         bus_wr,
    input  logic [1:0]   bus_op,
    input  logic [2:0]   bus_bsel,
    input  logic [7:0]   bus_wdata,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] ext_en,
    input  logic         pull_en,
    output logic [7:0]   rd_val,
    output logic [W-1:0] lat_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] res_o
);

    logic         hit_dat;
    logic         hit_ctl;
    logic [W-1:0] view;
    logic [7:0]   next_val;

    // Decode the two addresses owned by this bank.
    assign hit_dat = (bus_addr == DATA_ADDR);
    assign hit_ctl = (bus_addr == CTRL_ADDR);

    // Resolve each line: external driver wins, otherwise the pull option.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            res_o[i] = ext_en[i] ? pad_in[i] : pull_en;
        end
    end

    // Port view: input bits show the pad, output bits show the latch.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            view[i] = dir_q[i] ? res_o[i] : lat_q[i];
        end
    end

    // Read mux, zero-extended so unimplemented high bits read 0.
    always_comb begin
        rd_val = 8'h00;
        if (hit_dat) rd_val = 8'(view);
        else if (hit_ctl) rd_val = 8'(dir_q);
    end

    // Value stored by the current operation, based on what a read returns.
    assign next_val = apply_op(bus_op_e'(bus_op), bus_bsel, rd_val, bus_wdata);

    // Register update with synchronous reset to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '1;
            dir_q <= '1;
        end else if (bus_wr) begin
            if (hit_dat) lat_q <= next_val[W-1:0];
            if (hit_ctl) dir_q <= next_val[W-1:0];
        end
    end

endmodule

// File: rtl/gpio_buzz_mux.sv
// Module: port B pad driver with the complementary buzzer pair on lines
// 0 and 1. Assumes W >= 2. Drive enables always follow direction.
module gpio_buzz_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] lat,
    input  logic [W-1:0] dir,
    input  logic         buz_en,
    input  logic         tmr_tog,
    output logic [W-1:0] oe,
    output logic [W-1:0] out
);

    logic buz_p;
    logic buz_n;

    // Buzzer phases, both gated by the lowest line's latch bit only.
    assign buz_p = lat[0] & tmr_tog;
    assign buz_n = lat[0] & ~tmr_tog;

    // Drive enable is the inverse of the direction bit on every line.
    assign oe = ~dir;

    // Pad values: latch, with lines 0 and 1 replaced when buzzing.
    always_comb begin
        out = lat;
        if (buz_en) begin
            out[0] = buz_p;
            out[1] = buz_n;
        end
    end

endmodule

// File: rtl/gpio_wake_detect.sv
// Module: port A change detector. Samples the resolved levels every clock
// and pulses wake for one cycle when an input-mode line changed. Armed only
// after the first sample following reset.
module gpio_wake_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] res,
    input  logic [W-1:0] dir,
    output logic         wake
);

    logic [W-1:0] prev_q;
    logic         armed_q;
    logic [W-1:0] diff;

    // Changed lines that are currently inputs.
    assign diff = (res ^ prev_q) & dir;

    // Sample history, arm flag and registered wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '1;
            armed_q <= 1'b0;
            wake    <= 1'b0;
        end else begin
            prev_q  <= res;
            armed_q <= 1'b1;
            wake    <= armed_q && (|diff);
        end
    end

endmodule

// File: rtl/gpio_buzz_port.sv
// Module: top of the three-port I/O block. Assumes PA_W and PB_W up to 8,
// PB_W >= 2 for the buzzer pair, PC_W up to 8. Read data is combinational.
module gpio_buzz_port
    import gpio_buzz_pkg::*;
#(
    parameter int PA_W = 8,
    parameter int PB_W = 8,
    parameter int PC_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      bus_addr,
    input  logic            bus_wr,
    input  logic [1:0]      bus_op,
    input  logic [2:0]      bus_bsel,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    input  logic [2:0]      pull_en,
    input  logic            buz_en,
    input  logic            tmr_tog,
    input  logic [PA_W-1:0] pa_in,
    input  logic [PA_W-1:0] pa_ext,
    input  logic [PB_W-1:0] pb_in,
    input  logic [PB_W-1:0] pb_ext,
    input  logic [PC_W-1:0] pc_in,
    input  logic [PC_W-1:0] pc_ext,
    output logic [PA_W-1:0] pa_oe,
    output logic [PA_W-1:0] pa_out,
    output logic [PB_W-1:0] pb_oe,
    output logic [PB_W-1:0] pb_out,
    output logic [PC_W-1:0] pc_oe,
    output logic [PC_W-1:0] pc_out,
    output logic            wake
);

    logic [7:0]      rd_a, rd_b, rd_c;
    logic [PA_W-1:0] lat_a, dir_a, res_a;
    logic [PB_W-1:0] lat_b, dir_b, res_b;
    logic [PC_W-1:0] lat_c, dir_c, res_c;

    gpio_port_bank #(.W(PA_W), .DATA_ADDR(ADDR_A_DAT), .CTRL_ADDR(ADDR_A_CTL)) u_bank_a (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_op(bus_op), .bus_bsel(bus_bsel), .bus_wdata(bus_wdata),
        .pad_in(pa_in), .ext_en(pa_ext), .pull_en(pull_en[0]),
        .rd_val(rd_a), .lat_q(lat_a), .dir_q(dir_a), .res_o(res_a)
    );

    gpio_port_bank #(.W(PB_W), .DATA_ADDR(ADDR_B_DAT), .CTRL_ADDR(ADDR_B_CTL)) u_bank_b (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_op(bus_op), .bus_bsel(bus_bsel), .bus_wdata(bus_wdata),
        .pad_in(pb_in), .ext_en(pb_ext), .pull_en(pull_en[1]),
        .rd_val(rd_b), .lat_q(lat_b), .dir_q(dir_b), .res_o(res_b)
    );

    gpio_port_bank #(.W(PC_W), .DATA_ADDR(ADDR_C_DAT), .CTRL_ADDR(ADDR_C_CTL)) u_bank_c (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_op(bus_op), .bus_bsel(bus_bsel), .bus_wdata(bus_wdata),
        .pad_in(pc_in), .ext_en(pc_ext), .pull_en(pull_en[2]),
        .rd_val(rd_c), .lat_q(lat_c), .dir_q(dir_c), .res_o(res_c)
    );

    // Banks return 0 when not addressed, so their reads combine by OR.
    assign bus_rdata = rd_a | rd_b | rd_c;

    // Ports A and C drive their latches straight to the pads.
    assign pa_oe  = ~dir_a;
    assign pa_out = lat_a;
    assign pc_oe  = ~dir_c;
    assign pc_out = lat_c;

    gpio_buzz_mux #(.W(PB_W)) u_mux_b (
        .lat(lat_b), .dir(dir_b), .buz_en(buz_en), .tmr_tog(tmr_tog),
        .oe(pb_oe), .out(pb_out)
    );

    gpio_wake_detect #(.W(PA_W)) u_wake (
        .clk(clk), .rst_n(rst_n), .res(res_a), .dir(dir_a), .wake(wake)
    );

    // Lines of res_b and res_c only feed reads; tie them to a used net.
    logic unused_ok;
    assign unused_ok = ^{res_b, res_c};

endmodule

// File: rtl/gpio_buzz_port_chk.sv
// Checker: temporal properties on the top module's ports, bound below.
module gpio_buzz_port_chk
    import gpio_buzz_pkg::*;
#(
    parameter int PA_W = 8,
    parameter int PB_W = 8,
    parameter int PC_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [7:0]      bus_addr,
    input logic            bus_wr,
    input logic [1:0]      bus_op,
    input logic [7:0]      bus_wdata,
    input logic [7:0]      bus_rdata,
    input logic            buz_en,
    input logic [PA_W-1:0] pa_oe,
    input logic [PB_W-1:0] pb_oe,
    input logic [PB_W-1:0] pb_out,
    input logic [PC_W-1:0] pc_oe,
    input logic            wake
);

    // R1: the cycle after a reset edge, no line is driven.
    p_reset_inputs_r1: assert property (@(posedge clk)
        !rst_n |=> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0));

    // R2: a plain write to port A direction shows up inverted on the enables.
    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_op == 2'd0 && bus_addr == ADDR_A_CTL)
        |=> (pa_oe == ~$past(bus_wdata[PA_W-1:0])));

    // R7: unimplemented port C bits always read 0.
    p_pc_high_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_C_DAT || bus_addr == ADDR_C_CTL)
        |-> (bus_rdata[7:PC_W] == '0));

    // R8: the buzzer pair never drives both lines high at once.
    p_buzz_complement_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (buz_en && pb_oe[1:0] == 2'b11) |-> !(pb_out[0] && pb_out[1]));

    // R11: a wake pulse needs at least one port A input line a cycle earlier.
    p_wake_needs_input_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ($past(pa_oe) != '1));

endmodule

bind gpio_buzz_port gpio_buzz_port_chk #(.PA_W(PA_W), .PB_W(PB_W), .PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_op(bus_op), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .buz_en(buz_en), .pa_oe(pa_oe), .pb_oe(pb_oe), .pb_out(pb_out),
    .pc_oe(pc_oe), .wake(wake)
);

// File: tb/gpio_buzz_port_bench.sv
// Bench: random register traffic and pad stimulus plus directed corners,
// checked against a mirror model built from the requirements.
module gpio_buzz_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_op = 2'd0;
    logic [2:0] bus_bsel = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [2:0] pull_en = 3'b111;
    logic       buz_en = 1'b0;
    logic       tmr_tog = 1'b0;
    logic [7:0] pa_in = 8'h00, pa_ext = 8'h00;
    logic [7:0] pb_in = 8'h00, pb_ext = 8'h00;
    logic [4:0] pc_in = 5'h00, pc_ext = 5'h00;
    logic [7:0] pa_oe, pa_out, pb_oe, pb_out;
    logic [4:0] pc_oe, pc_out;
    logic       wake;

    int vectors = 0;
    int fails = 0;
    logic [7:0] m_lat [3];
    logic [7:0] m_dir [3];

    always #10 clk = ~clk;

    gpio_buzz_port u_gpio_buzz_port (.*);

    function automatic logic [7:0] pmask(int p);
        return (p == 2) ? 8'h1F : 8'hFF;
    endfunction

    function automatic logic [7:0] resolved(int p);
        logic [7:0] pin, ext;
        pin = (p == 0) ? pa_in : (p == 1) ? pb_in : {3'b0, pc_in};
        ext = (p == 0) ? pa_ext : (p == 1) ? pb_ext : {3'b0, pc_ext};
        return ((ext & pin) | (~ext & {8{pull_en[p]}})) & pmask(p);
    endfunction

    function automatic logic [7:0] exp_read(logic [7:0] a);
        int p;
        if (a < 8'h12 || a > 8'h17) return 8'h00;
        p = (int'(a) - 'h12) / 2;
        if (a[0]) return m_dir[p] & pmask(p);
        return ((m_dir[p] & resolved(p)) | (~m_dir[p] & m_lat[p])) & pmask(p);
    endfunction

    function automatic logic [7:0] exp_pb_out();
        logic [7:0] r;
        r = m_lat[1];
        if (buz_en) begin
            r[0] = m_lat[1][0] & tmr_tog;
            r[1] = m_lat[1][0] & ~tmr_tog;
        end
        return r;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Apply one bus operation at a negedge, update the model after the edge.
    task automatic bus_do(logic [7:0] a, logic [1:0] op, logic [2:0] b, logic [7:0] wd);
        logic [7:0] cur, nv;
        int p;
        @(negedge clk);
        bus_addr = a; bus_op = op; bus_bsel = b; bus_wdata = wd; bus_wr = 1'b1;
        #1;
        cur = exp_read(a);
        case (op)
            2'd0: nv = wd;
            2'd1: nv = cur | (8'b1 << b);
            2'd2: nv = cur & ~(8'b1 << b);
            default: nv = ~cur;
        endcase
        @(posedge clk);
        if (a >= 8'h12 && a <= 8'h17) begin
            p = (int'(a) - 'h12) / 2;
            if (a[0]) m_dir[p] = nv & pmask(p) | ~pmask(p);
            else m_lat[p] = nv & pmask(p) | ~pmask(p);
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Read every address and compare all pad outputs against the model.
    task automatic check_all(string req);
        for (int a = 8'h12; a <= 8'h17; a++) begin
            bus_addr = 8'(a);
            #1;
            chk(req, bus_rdata, exp_read(8'(a)));
        end
        chk(req, pa_oe, ~m_dir[0]);
        chk(req, pa_out, m_lat[0]);
        chk(req, pb_oe, ~m_dir[1]);
        chk(req, pb_out, exp_pb_out());
        chk(req, {3'b0, pc_oe}, ~m_dir[2] & 8'h1F);
        chk(req, {3'b0, pc_out}, m_lat[2] & 8'h1F);
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int p = 0; p < 3; p++) begin m_lat[p] = 8'hFF; m_dir[p] = 8'hFF; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state; R5 pulled-high undriven inputs read 1.
        check_all("R1");
        bus_addr = 8'h13; #1; chk("R1", bus_rdata, 8'hFF);
        bus_addr = 8'h16; #1; chk("R5", bus_rdata, 8'h1F);

        // R5 pull disabled, undriven inputs read 0; driven ones read the pad.
        pull_en = 3'b000; pa_ext = 8'h0F; pa_in = 8'h05;
        bus_addr = 8'h12; #1; chk("R5", bus_rdata, 8'h05);
        pull_en = 3'b111;

        // R2/R3 write data and direction; R4 mixed view.
        bus_do(8'h12, 2'd0, 3'd0, 8'hA5);
        bus_do(8'h13, 2'd0, 3'd0, 8'hF0);
        check_all("R3");
        bus_addr = 8'h12; #1; chk("R4", bus_rdata, 8'hF5);

        // R6 set, clear, complement.
        bus_do(8'h12, 2'd1, 3'd1, 8'h00);
        bus_addr = 8'h12; #1; chk("R6", pa_out, 8'hF7);
        bus_do(8'h12, 2'd2, 3'd0, 8'h00);
        #1; chk("R6", pa_out, 8'hF6);
        bus_do(8'h12, 2'd3, 3'd0, 8'h00);
        #1; chk("R6", pa_out, 8'h09);

        // R7 port C high bits.
        bus_do(8'h17, 2'd0, 3'd0, 8'h00);
        bus_do(8'h16, 2'd0, 3'd0, 8'hFF);
        bus_addr = 8'h16; #1; chk("R7", bus_rdata, 8'h1F);
        bus_do(8'h16, 2'd3, 3'd0, 8'h00);
        bus_addr = 8'h16; #1; chk("R7", bus_rdata, 8'h00);
        bus_addr = 8'h17; #1; chk("R7", bus_rdata, 8'h00);

        // R8/R9 buzzer pair, gated by B0 latch only.
        bus_do(8'h15, 2'd0, 3'd0, 8'hFC);
        buz_en = 1'b1;
        bus_do(8'h14, 2'd0, 3'd0, 8'h01);
        tmr_tog = 1'b1; #1; chk("R8", pb_out[1:0], 8'(2'b01));
        tmr_tog = 1'b0; #1; chk("R8", pb_out[1:0], 8'(2'b10));
        bus_do(8'h14, 2'd0, 3'd0, 8'h02);
        tmr_tog = 1'b1; #1; chk("R9", pb_out[1:0], 8'(2'b00));
        tmr_tog = 1'b0; #1; chk("R9", pb_out[1:0], 8'(2'b00));

        // R10 input mode with buzzer on reads pad.
        bus_do(8'h15, 2'd0, 3'd0, 8'hFF);
        pb_ext = 8'h03; pb_in = 8'h02;
        bus_addr = 8'h14; #1; chk("R10", bus_rdata, 8'hFE);
        chk("R10", pb_oe, 8'h00);

        // R11 wake on input change only.
        bus_do(8'h13, 2'd0, 3'd0, 8'h0F);
        pa_ext = 8'hFF; pa_in = 8'h00;
        @(negedge clk); @(negedge clk);
        chk("R11", {7'b0, wake}, 8'h00);
        pa_in = 8'h01;
        @(negedge clk); chk("R11", {7'b0, wake}, 8'h01);
        @(negedge clk); chk("R11", {7'b0, wake}, 8'h00);
        pa_in = 8'h81;
        @(negedge clk); chk("R11", {7'b0, wake}, 8'h00);
        @(negedge clk); chk("R11", {7'b0, wake}, 8'h00);

        // R1 reset again: first edge after reset never wakes.
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        for (int p = 0; p < 3; p++) begin m_lat[p] = 8'hFF; m_dir[p] = 8'hFF; end
        pa_in = 8'h7E;
        @(negedge clk); chk("R11", {7'b0, wake}, 8'h00);
        check_all("R1");

        // Random traffic: R2 R3 R4 R5 R6 R8.
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            pa_in = 8'($urandom); pa_ext = 8'($urandom);
            pb_in = 8'($urandom); pb_ext = 8'($urandom);
            pc_in = 5'($urandom); pc_ext = 5'($urandom);
            pull_en = 3'($urandom); buz_en = 1'($urandom); tmr_tog = 1'($urandom);
            bus_do(8'(8'h12 + $urandom_range(0, 5)), 2'($urandom), 3'($urandom), 8'($urandom));
            check_all("R6");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule